// File: doc/BRIEF.md
# Hot-Swap Power-Good Sequencer

This block is the digital supervisor of a hot-swap power path. When `run_i` requests power, it drives the gate enable of the external pass FET. It then holds a timed window in which the active-low shutdown feedback from the secondary side is not looked at. The downstream converters need that time to come up, and until then they cannot drive the feedback line.

After the window closes, a low level on the shutdown feedback is treated as a fault. The block turns the gate off, drops power-good and holds an active-low fault output until restarted. A mode input instead makes that feedback a second qualifier of power-good.

Power-good (active low) is released once four things hold together: the drain-sense comparator reports a low drain voltage, the gate has once been seen high, the power-good enable is high, and a delay picked from an eight-entry table has run out. The drain-sense check is waived while the external current regulation is active. All timing is counted in 1 µs ticks taken from a prescaled system clock.

Top module: `pg_sequencer`

## Requirements
- R1: After `gate_en_o` rises, a low `fs_ni` raises no fault until `HOLDOFF_TICKS` ticks have been counted.
- R2: With `fs_as_en_i` low, `fs_ni` low after the holdoff window sets the fault state. In that state `fault_no` is 0, `gate_en_o` is 0 and `pg_no` is 1.
- R3: `pg_no` can be 0 only while `pg_en_i` is 1 and the gate-high condition and drain condition are both met.
- R4: The gate-high condition is captured the first time `gate_hi_i` is 1 while `gate_en_o` is 1. It stays met until the gate is turned off, even if `gate_hi_i` falls.
- R5: The drain condition is met when `ds_low_i` is 1 or while `curr_reg_i` is 1. Losing the drain condition releases power-good at once.
- R6: Power-good asserts after the selected delay of continuous qualification. The delay in ticks is chosen by `pg_dly_sel_i`: 0 gives 50, 1 gives 200, 2 gives 1000, 3 gives 5000, 4 gives 10000, 5 gives 40000, 6 gives 80000 and 7 gives 160000.
- R7: With `fs_as_en_i` high, `fs_ni` never causes a fault. Instead `fs_ni` must be 1 for power-good to be qualified.
- R8: One tick is `TICK_DIV` clock cycles, and ticks are never back to back when `TICK_DIV` > 1.
- R9: The fault state persists until a rising edge on `restart_i` or a reset. After the restart the block returns to idle, and from idle it powers up again if `run_i` is high.
- R10: Once qualification is lost, the delay count is cleared. The full delay runs again from the start when qualification returns.
- R11: After reset `gate_en_o` is 0, `pg_no` is 1 and `fault_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Power-up request |
| restart_i | input | 1 | Rising edge clears a fault |
| fs_ni | input | 1 | Shutdown feedback, active low |
| fs_as_en_i | input | 1 | 1: feedback acts as a second power-good enable |
| ds_low_i | input | 1 | Drain-sense comparator: drain below threshold |
| curr_reg_i | input | 1 | Current regulation active, waives drain check |
| gate_hi_i | input | 1 | Gate-voltage comparator: gate above threshold |
| pg_en_i | input | 1 | Power-good enable |
| pg_dly_sel_i | input | 3 | Power-good delay select |
| gate_en_o | output | 1 | Gate drive enable |
| pg_no | output | 1 | Power-good, active low |
| fault_no | output | 1 | Fault, active low |

## Verification
The hardest situation to reach is a shutdown-feedback low that lands inside the holdoff window and then persists past its end. The bench needs the fault to be absent at one point and present at a later one, with no other input changing. To get there, the feedback is pulled low in the same cycle as the power-up request. The outputs are then sampled at a point well inside the tick-quantised window and at a point well past it.

A similar problem arises for the latched gate-high condition. It is reached by pulsing the comparator flag once during holdoff and holding it low until the delay expires.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_RUN, ST_FAULT} seq_state_e;

  localparam int unsigned PGD_MAX_TICKS = 160000;
  localparam int unsigned PGD_W         = $clog2(PGD_MAX_TICKS + 1);

  function automatic logic [PGD_W-1:0] pgd_ticks(input logic [2:0] sel);
    logic [PGD_W-1:0] t;
    case (sel)
      3'd0:    t = PGD_W'(50);
      3'd1:    t = PGD_W'(200);
      3'd2:    t = PGD_W'(1000);
      3'd3:    t = PGD_W'(5000);
      3'd4:    t = PGD_W'(10000);
      3'd5:    t = PGD_W'(40000);
      3'd6:    t = PGD_W'(80000);
      default: t = PGD_W'(PGD_MAX_TICKS);
    endcase
    return t;
  endfunction
endpackage

// File: rtl/pgs_tick_gen.sv
module pgs_tick_gen #(
  parameter int unsigned TICK_DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          cnt_q <= '0;
        else if (cnt_q == CW'(TICK_DIV - 1))  cnt_q <= '0;
        else                                  cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(TICK_DIV - 1));

      a_r8_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pgs_seq_fsm.sv
module pgs_seq_fsm
  import pgs_pkg::*;
#(
  parameter int unsigned HOLDOFF_TICKS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic       fs_ni,
  input  logic       fs_as_en_i,
  output seq_state_e state_o,
  output logic       gate_en_o,
  output logic       fault_o,
  output logic       run_o
);
  localparam int unsigned HW = $clog2(HOLDOFF_TICKS + 1);

  seq_state_e state_q, state_d;
  logic [HW-1:0] hcnt_q;
  logic restart_q, restart_rise, hold_done;

  assign restart_rise = restart_i & ~restart_q;
  assign hold_done    = tick_i && (hcnt_q >= HW'(HOLDOFF_TICKS - 1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (run_i) state_d = ST_HOLD;
      ST_HOLD:  if (!run_i) state_d = ST_IDLE;
                else if (hold_done) state_d = ST_RUN;
      ST_RUN:   if (!run_i) state_d = ST_IDLE;
                else if (!fs_as_en_i && !fs_ni) state_d = ST_FAULT;
      ST_FAULT: if (restart_rise) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      hcnt_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_i;
      if (state_q != ST_HOLD)  hcnt_q <= '0;
      else if (tick_i)         hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign state_o   = state_q;
  assign gate_en_o = (state_q == ST_HOLD) || (state_q == ST_RUN);
  assign fault_o   = (state_q == ST_FAULT);
  assign run_o     = (state_q == ST_RUN);

  // feedback is blind during holdoff
  a_r1_holdoff_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_en_o) |=> !fault_o);
  a_r9_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !restart_i |=> fault_o);
  a_r7_mode_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o && fs_as_en_i |=> !fault_o);
endmodule

// File: rtl/pgs_pg_timer.sv
module pgs_pg_timer
  import pgs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       qual_i,
  input  logic [2:0] sel_i,
  output logic       done_o
);
  logic [PGD_W-1:0] cnt_q, target;

  assign target = pgd_ticks(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!qual_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q < target)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= target);

  a_r10_restart_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual_i |=> !done_o);
  a_r6_done_needs_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(qual_i));
endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
  import pgs_pkg::*;
#(
  parameter int unsigned TICK_DIV      = 100,
  parameter int unsigned HOLDOFF_TICKS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic       fs_ni,
  input  logic       fs_as_en_i,
  input  logic       ds_low_i,
  input  logic       curr_reg_i,
  input  logic       gate_hi_i,
  input  logic       pg_en_i,
  input  logic [2:0] pg_dly_sel_i,
  output logic       gate_en_o,
  output logic       pg_no,
  output logic       fault_no
);
  seq_state_e state;
  logic tick, gate_en, fault, running;
  logic gate_seen_q, ds_ok, fs_ok, qual, dly_done;

  pgs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  pgs_seq_fsm #(.HOLDOFF_TICKS(HOLDOFF_TICKS)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .run_i(run_i),
    .restart_i(restart_i), .fs_ni(fs_ni), .fs_as_en_i(fs_as_en_i),
    .state_o(state), .gate_en_o(gate_en), .fault_o(fault), .run_o(running)
  );

  // gate-high seen once per power-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gate_seen_q <= 1'b0;
    else if (!gate_en) gate_seen_q <= 1'b0;
    else if (gate_hi_i) gate_seen_q <= 1'b1;
  end

  assign ds_ok = ds_low_i | curr_reg_i;
  assign fs_ok = ~fs_as_en_i | fs_ni;
  assign qual  = running & gate_seen_q & ds_ok & pg_en_i & fs_ok;

  pgs_pg_timer u_pgt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .qual_i(qual),
    .sel_i(pg_dly_sel_i), .done_o(dly_done)
  );

  assign gate_en_o = gate_en;
  assign fault_no  = ~fault;
  assign pg_no     = ~(qual & dly_done);

  a_r2_fault_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_no |-> !gate_en_o && pg_no);
  a_r3_pg_quals: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_no |-> pg_en_i && gate_seen_q && (ds_low_i || curr_reg_i));
  a_r4_gate_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_seen_q && gate_en_o |=> gate_seen_q || !gate_en_o);
  a_r7_second_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_as_en_i && !fs_ni |-> pg_no);
  a_r11_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !gate_en_o && pg_no && fault_no);
endmodule

// File: tb/sim_pg_sequencer.sv
`timescale 1ns/1ps
module sim_pg_sequencer;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run_i = 0, restart_i = 0, fs_ni = 1, fs_as_en_i = 0;
  logic ds_low_i = 0, curr_reg_i = 0, gate_hi_i = 0, pg_en_i = 0;
  logic [2:0] pg_dly_sel_i = 3'd0;
  logic gate_en_o, pg_no, fault_no;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  pg_sequencer #(.TICK_DIV(4), .HOLDOFF_TICKS(10)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .restart_i(restart_i),
    .fs_ni(fs_ni), .fs_as_en_i(fs_as_en_i), .ds_low_i(ds_low_i),
    .curr_reg_i(curr_reg_i), .gate_hi_i(gate_hi_i), .pg_en_i(pg_en_i),
    .pg_dly_sel_i(pg_dly_sel_i), .gate_en_o(gate_en_o), .pg_no(pg_no),
    .fault_no(fault_no)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    run_i = 0; restart_i = 0; fs_ni = 1; fs_as_en_i = 0;
    ds_low_i = 0; curr_reg_i = 0; gate_hi_i = 0; pg_en_i = 0; pg_dly_sel_i = 0;
    wait_n(2);
    rst_ni = 1;
    wait_n(1);
  endtask

  // holdoff ends about 40 cycles after run_i; delay 0 adds about 200
  task automatic power_up(input logic [2:0] sel);
    pg_dly_sel_i = sel; ds_low_i = 1; gate_hi_i = 1; pg_en_i = 1; fs_ni = 1;
    run_i = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 gate_en", gate_en_o, 1'b0);
    chk("R11 pg_no", pg_no, 1'b1);
    chk("R11 fault_no", fault_no, 1'b1);
  endtask

  task automatic t_holdoff_fault();
    do_reset();
    power_up(3'd0);
    fs_ni = 0;
    wait_n(28);
    chk("R1 no fault in holdoff", fault_no, 1'b1);
    chk("R1 gate on in holdoff", gate_en_o, 1'b1);
    wait_n(32);
    chk("R2 fault_no", fault_no, 1'b0);
    chk("R2 gate off", gate_en_o, 1'b0);
    chk("R2 pg off", pg_no, 1'b1);
  endtask

  task automatic t_fault_restart();
    fs_ni = 1;
    wait_n(50);
    chk("R9 fault sticky", fault_no, 1'b0);
    restart_i = 1;
    wait_n(2);
    chk("R9 fault cleared", fault_no, 1'b1);
    restart_i = 0;
    wait_n(5);
    chk("R9 powers up again", gate_en_o, 1'b1);
  endtask

  task automatic t_delay_sel0();
    do_reset();
    power_up(3'd0);
    wait_n(225);
    chk("R6 sel0 early", pg_no, 1'b1);
    wait_n(35);
    chk("R6 sel0 asserted", pg_no, 1'b0);
  endtask

  task automatic t_drain();
    // pg is on here
    curr_reg_i = 1; ds_low_i = 0;
    wait_n(10);
    chk("R5 drain waived under regulation", pg_no, 1'b0);
    curr_reg_i = 0;
    #1;
    chk("R5 drain loss immediate", pg_no, 1'b1);
    wait_n(5);
    ds_low_i = 1;
    wait_n(150);
    chk("R10 delay restarted", pg_no, 1'b1);
    wait_n(80);
    chk("R10 delay completes again", pg_no, 1'b0);
    pg_en_i = 0;
    #1;
    chk("R3 enable low drops pg", pg_no, 1'b1);
  endtask

  task automatic t_delay_sel1();
    do_reset();
    power_up(3'd1);
    wait_n(820);
    chk("R6 sel1 early", pg_no, 1'b1);
    wait_n(50);
    chk("R6 sel1 asserted", pg_no, 1'b0);
  endtask

  task automatic t_gate_latch();
    do_reset();
    power_up(3'd0);
    wait_n(5);
    gate_hi_i = 0;
    wait_n(255);
    chk("R4 latched gate-high", pg_no, 1'b0);
    do_reset();
    power_up(3'd0);
    gate_hi_i = 0;
    wait_n(300);
    chk("R4 never seen gate-high", pg_no, 1'b1);
  endtask

  task automatic t_mode();
    do_reset();
    fs_as_en_i = 1;
    power_up(3'd0);
    fs_ni = 0;
    wait_n(300);
    chk("R7 no fault in mode", fault_no, 1'b1);
    chk("R7 fs low blocks pg", pg_no, 1'b1);
    fs_ni = 1;
    wait_n(150);
    chk("R7 delay still running", pg_no, 1'b1);
    wait_n(70);
    chk("R7 fs high allows pg", pg_no, 1'b0);
  endtask

  task automatic t_tick();
    do_reset();
    power_up(3'd0);
    wait_n(25);
    chk("R8 holdoff scaled by prescaler", gate_en_o, 1'b1);
    run_i = 0;
    wait_n(2);
    chk("R8 run drop returns idle", gate_en_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_holdoff_fault();
    t_fault_restart();
    t_delay_sel0();
    t_drain();
    t_delay_sel1();
    t_gate_latch();
    t_mode();
    t_tick();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule